// File: doc/BRIEF.md
# Block-Transfer DMA Controller

This block moves a block of words between a peripheral data port and memory without processor involvement. Software programs a start address, a remaining-word count and a direction through a small register port. A separate start command then launches the move. The controller asks for the shared bus and holds the request until the arbiter grants it. It then runs one burst: for every word it performs one peripheral handshake and one memory cycle. After the last word it gives the bus back with a one-cycle release pulse.

Completion is reported by an interrupt line. The line stays high until software clears it through the status register. While a block is in flight the controller refuses new programming, and a status bit shows that it is busy. The address advances by one word and the count drops by one for every completed word. A block whose count is zero finishes at once and never touches the bus.

Top module: `blkmove_dma`

## Requirements
- R1: The register port decodes `cfg_sel` as follows. Selector 0 is the word address, selector 1 is the remaining count, and selector 2 is control. Control bit 0 is the direction (0 = peripheral to memory, 1 = memory to peripheral) and control bit 1 is start. Selector 3 is status: reading it gives bit 0 = interrupt and bit 1 = busy. Reading selectors 0 and 1 returns the live address and count.
- R2: Writing the address and count registers without a start command causes no bus request and no transfer.
- R3: `bus_req` rises after start and stays high until the release. `mem_rd` and `mem_wr` are asserted only while both `bus_req` and `bus_gnt` are high.
- R4: In the peripheral-to-memory direction, each word follows the same order. `per_req` is held until `per_ack` arrives, and the data on `per_rdata` is captured. Then `mem_wr` is held with that data at the current address until `mem_ack` arrives. No memory write happens before the peripheral has supplied the data for that word.
- R5: In the memory-to-peripheral direction, each word follows the same order. `mem_rd` is held until `mem_ack` arrives, and the data on `mem_rdata` is captured. Then `per_req` is held with that data on `per_wdata` until `per_ack` arrives.
- R6: Each completed word raises the address by one and lowers the count by one. Exactly the programmed number of words is moved.
- R7: After the last word, `bus_req` falls and `bus_rel` is high for exactly one cycle. The interrupt is set in the following cycle.
- R8: A start with a count of zero sets the interrupt two cycles later, with no bus request and no memory or peripheral cycle.
- R9: Busy reads 1 from the cycle after start until the cycle the interrupt is set. The interrupt stays high until a status write with bit 0 = 1 clears it.
- R10: Writes to the address, count or control registers while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data for `cfg_sel` |
| irq | output | 1 | Block-done interrupt |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rel | output | 1 | One-cycle bus release pulse |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory cycle complete |
| per_req | output | 1 | Peripheral handshake request |
| per_ack | input | 1 | Peripheral data valid / accepted |
| per_rdata | input | DATA_W | Data from peripheral |
| per_wdata | output | DATA_W | Data to peripheral |

## Verification
The bench builds the block with its defaults: a 16-bit address and data path and an 8-bit count. This keeps the touched addresses inside a 256-word bench memory while still allowing blocks of up to 255 words. The memory, peripheral and arbiter models have programmable wait states. These let the runs reach grant delays, stalled handshakes in both directions, and programming attempts that land mid-burst. Zero-count starts and interrupt clearing are driven at the ports.

// File: rtl/blkmove_dma_pkg.sv
package blkmove_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_PGET, ST_MWR, ST_MRD, ST_PPUT, ST_REL, ST_FIN
  } mover_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_DIR_BIT   = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int STAT_CLR_BIT   = 0;
endpackage

// File: rtl/blkmove_dma_regs.sv
module blkmove_dma_regs
  import blkmove_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              busy,
  input  logic              advance,
  input  logic              finish,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              dir,
  output logic              irq,
  output logic              start_pulse,
  output logic              cnt_zero,
  output logic              cnt_one,
  output logic              clear_hit
);
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic idle_wr;
  assign idle_wr     = cfg_we && !busy;
  assign start_pulse = idle_wr && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_START_BIT];
  assign clear_hit   = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[STAT_CLR_BIT];
  assign cnt_zero    = (cur_cnt == '0);
  assign cnt_one     = (cur_cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      dir      <= 1'b0;
    end else if (advance) begin
      cur_addr <= addr_next(cur_addr);
      cur_cnt  <= cnt_next(cur_cnt);
    end else if (idle_wr) begin
      case (cfg_sel)
        SEL_ADDR: cur_addr <= cfg_wdata;
        SEL_CNT:  cur_cnt  <= cfg_wdata[CNT_W-1:0];
        SEL_CTRL: dir      <= cfg_wdata[CTRL_DIR_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (finish)    irq <= 1'b1;
    else if (clear_hit) irq <= 1'b0;
  end

  always_comb begin
    case (cfg_sel)
      SEL_ADDR: cfg_rdata = cur_addr;
      SEL_CNT:  cfg_rdata = ADDR_W'(cur_cnt);
      SEL_CTRL: cfg_rdata = ADDR_W'(dir);
      default:  cfg_rdata = ADDR_W'({busy, irq});
    endcase
  end
endmodule

// File: rtl/blkmove_dma_seq.sv
module blkmove_dma_seq
  import blkmove_dma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic              cnt_zero,
  input  logic              cnt_one,
  input  logic              bus_gnt,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_ack,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              bus_req,
  output logic              bus_rel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              per_req,
  output logic [DATA_W-1:0] data_q,
  output logic              advance,
  output logic              finish,
  output logic              busy
);
  mover_state_t state, state_n;

  always_comb begin
    state_n = state;
    advance = 1'b0;
    case (state)
      ST_IDLE: if (start) state_n = cnt_zero ? ST_FIN : ST_ARB;
      ST_ARB:  if (bus_gnt) state_n = dir ? ST_MRD : ST_PGET;
      ST_PGET: if (per_ack) state_n = ST_MWR;
      ST_MWR:  if (mem_ack) begin
                 advance = 1'b1;
                 state_n = cnt_one ? ST_REL : ST_PGET;
               end
      ST_MRD:  if (mem_ack) state_n = ST_PPUT;
      ST_PPUT: if (per_ack) begin
                 advance = 1'b1;
                 state_n = cnt_one ? ST_REL : ST_MRD;
               end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
    end else begin
      state <= state_n;
      if (state == ST_PGET && per_ack) data_q <= per_rdata;
      if (state == ST_MRD && mem_ack)  data_q <= mem_rdata;
    end
  end

  assign bus_req = (state == ST_ARB) || (state == ST_PGET) || (state == ST_MWR) ||
                   (state == ST_MRD) || (state == ST_PPUT);
  assign bus_rel = (state == ST_REL);
  assign mem_rd  = (state == ST_MRD);
  assign mem_wr  = (state == ST_MWR);
  assign per_req = (state == ST_PGET) || (state == ST_PPUT);
  assign finish  = (state == ST_REL) || (state == ST_FIN);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_rel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              per_req,
  input  logic              per_ack,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [DATA_W-1:0] per_wdata
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic [DATA_W-1:0] data_q;
  logic dir, busy, word_done, finish, start_pulse, cnt_zero, cnt_one, clear_hit;
  logic start_zero;

  assign start_zero = start_pulse && cnt_zero;

  blkmove_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .advance(word_done), .finish(finish), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .dir(dir), .irq(irq), .start_pulse(start_pulse),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one), .clear_hit(clear_hit)
  );

  blkmove_dma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .dir(dir),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one), .bus_gnt(bus_gnt),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .per_ack(per_ack),
    .per_rdata(per_rdata), .bus_req(bus_req), .bus_rel(bus_rel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .per_req(per_req), .data_q(data_q),
    .advance(word_done), .finish(finish), .busy(busy)
  );

  assign mem_addr  = cur_addr;
  assign mem_wdata = data_q;
  assign per_wdata = data_q;
endmodule

// File: rtl/blkmove_dma_chk.sv
module blkmove_dma_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             bus_rel,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             per_req,
  input logic             irq,
  input logic             dir,
  input logic             busy,
  input logic             word_done,
  input logic             clear_hit,
  input logic             start_zero,
  input logic [CNT_W-1:0] cnt
);
  a_r3_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

  a_r4_write_only_inbound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !dir);

  a_r5_read_only_outbound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> dir);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, per_req}));

  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

  a_r7_release_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rel |-> !bus_req);

  a_r7_release_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rel |=> (!bus_rel && irq));

  a_r8_zero_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |=> !bus_req ##1 (irq && !bus_req));

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear_hit) |=> irq);

  a_r9_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);
endmodule

bind blkmove_dma blkmove_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_rel(bus_rel), .mem_rd(mem_rd), .mem_wr(mem_wr), .per_req(per_req),
  .irq(irq), .dir(dir), .busy(busy), .word_done(word_done),
  .clear_hit(clear_hit), .start_zero(start_zero), .cnt(cur_cnt)
);

// File: tb/blkmove_dma_test.sv
`timescale 1ns/1ps
module blkmove_dma_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic irq, bus_req, bus_rel, mem_rd, mem_wr, per_req;
  logic bus_gnt = 1'b0;
  logic mem_ack = 1'b0;
  logic per_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, per_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] per_rdata = '0;

  always #4 clk = ~clk;

  blkmove_dma #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rel(bus_rel),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .per_req(per_req), .per_ack(per_ack), .per_rdata(per_rdata),
    .per_wdata(per_wdata)
  );

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] sink [0:15];
  int gnt_delay, mem_wait, per_wait;
  int gcnt, mleft, pleft, per_idx;
  int saw_req, rel_seen, gnt_viol, order_viol, per_given, mem_writes, mem_cycles;
  int checks, fails;
  bit finished;

  // Environment models: arbiter, memory, peripheral
  always @(negedge clk) begin
    if (bus_req) saw_req++;
    if (bus_rel) rel_seen++;
    if ((mem_rd || mem_wr) && !bus_gnt) gnt_viol++;
    if (!bus_req) begin bus_gnt = 1'b0; gcnt = 0; end
    else if (gcnt >= gnt_delay) bus_gnt = 1'b1;
    else gcnt++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_rd || mem_wr) begin
      if (mleft > 0) mleft--;
      else begin
        mem_cycles++;
        if (mem_wr) begin
          if (mem_writes >= per_given) order_viol++;
          mem[mem_addr[7:0]] = mem_wdata;
          mem_writes++;
        end else mem_rdata = mem[mem_addr[7:0]];
        mem_ack = 1'b1;
        mleft = mem_wait;
      end
    end
    if (per_ack) per_ack = 1'b0;
    else if (per_req) begin
      if (pleft > 0) pleft--;
      else begin
        if (mem_rd || mem_wr) order_viol++;
        per_rdata = DW'(16'hA000 + per_idx);
        sink[per_idx[3:0]] = per_wdata;
        per_idx++;
        per_given++;
        per_ack = 1'b1;
        pleft = per_wait;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [AW-1:0] d);
    cfg_sel = sel;
    #1;
    d = cfg_rdata;
  endtask

  task automatic reset_env(input int gd, input int mw, input int pw);
    gnt_delay = gd; mem_wait = mw; per_wait = pw;
    mleft = mw; pleft = pw; per_idx = 0;
    saw_req = 0; rel_seen = 0; gnt_viol = 0; order_viol = 0;
    per_given = 0; mem_writes = 0; mem_cycles = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic clear_irq();
    cfg_write(2'd3, 16'h0001);
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    cfg_read(2'd3, v);
    chk(v == 0, "R9", "status after reset", v, 0);
    chk(bus_req == 1'b0, "R3", "bus_req after reset", bus_req, 0);
  endtask

  task automatic t_load_only();
    logic [AW-1:0] v;
    reset_env(0, 0, 0);
    cfg_write(2'd0, 16'h0020);
    cfg_write(2'd1, 16'h0004);
    repeat (10) @(negedge clk);
    chk(saw_req == 0, "R2", "bus request without start", saw_req, 0);
    cfg_read(2'd0, v);
    chk(v == 16'h0020, "R1", "address readback", v, 16'h0020);
    cfg_read(2'd1, v);
    chk(v == 16'h0004, "R1", "count readback", v, 4);
  endtask

  task automatic t_inbound();
    logic [AW-1:0] v;
    reset_env(2, 1, 1);
    mem[8'h24] = 16'h5555;
    cfg_write(2'd2, 16'h0002);
    cfg_read(2'd3, v);
    chk(v[1] == 1'b1, "R9", "busy after start", v[1], 1);
    wait_irq();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h20 + i] == DW'(16'hA000 + i), "R4", "inbound word",
          mem[8'h20 + i], 16'hA000 + i);
    chk(mem[8'h24] == 16'h5555, "R6", "word past block untouched", mem[8'h24], 16'h5555);
    chk(mem_writes == 4, "R6", "memory writes", mem_writes, 4);
    cfg_read(2'd0, v);
    chk(v == 16'h0024, "R6", "final address", v, 16'h0024);
    cfg_read(2'd1, v);
    chk(v == 0, "R6", "final count", v, 0);
    chk(rel_seen == 1, "R7", "release pulses", rel_seen, 1);
    chk(bus_req == 1'b0, "R7", "bus_req after done", bus_req, 0);
    chk(gnt_viol == 0, "R3", "strobe without grant", gnt_viol, 0);
    chk(order_viol == 0, "R4", "write before peripheral data", order_viol, 0);
    cfg_read(2'd3, v);
    chk(v == 16'h0001, "R9", "status irq=1 busy=0", v, 1);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R9", "irq held", irq, 1);
    clear_irq();
    chk(irq == 1'b0, "R9", "irq cleared", irq, 0);
  endtask

  task automatic t_outbound();
    logic [AW-1:0] v;
    reset_env(3, 2, 2);
    for (int i = 0; i < 5; i++) mem[8'h40 + i] = DW'(16'h3C00 + 7 * i);
    cfg_write(2'd0, 16'h0040);
    cfg_write(2'd1, 16'h0005);
    cfg_write(2'd2, 16'h0003);
    wait_irq();
    for (int i = 0; i < 5; i++)
      chk(sink[i] == DW'(16'h3C00 + 7 * i), "R5", "outbound word",
          sink[i], 16'h3C00 + 7 * i);
    chk(mem_writes == 0, "R5", "no memory writes outbound", mem_writes, 0);
    chk(mem_cycles == 5, "R6", "memory reads", mem_cycles, 5);
    cfg_read(2'd0, v);
    chk(v == 16'h0045, "R6", "final address outbound", v, 16'h0045);
    chk(gnt_viol == 0, "R3", "strobe without grant outbound", gnt_viol, 0);
    chk(rel_seen == 1, "R7", "release pulses outbound", rel_seen, 1);
    clear_irq();
  endtask

  task automatic t_busy_ignore();
    logic [AW-1:0] v;
    reset_env(1, 0, 4);
    mem[8'h90] = 16'h7777;
    cfg_write(2'd0, 16'h0060);
    cfg_write(2'd1, 16'h0003);
    cfg_write(2'd2, 16'h0002);
    cfg_write(2'd0, 16'h0090);
    cfg_write(2'd1, 16'h0009);
    cfg_write(2'd2, 16'h0003);
    wait_irq();
    chk(mem_writes == 3, "R10", "writes after mid-burst programming", mem_writes, 3);
    chk(mem[8'h62] == 16'hA002, "R10", "last word of original block", mem[8'h62], 16'hA002);
    chk(mem[8'h90] == 16'h7777, "R10", "ignored address untouched", mem[8'h90], 16'h7777);
    cfg_read(2'd0, v);
    chk(v == 16'h0063, "R10", "address kept", v, 16'h0063);
    cfg_read(2'd2, v);
    chk(v == 0, "R10", "direction kept", v, 0);
    clear_irq();
  endtask

  task automatic t_zero();
    reset_env(0, 0, 0);
    cfg_write(2'd1, 16'h0000);
    cfg_write(2'd2, 16'h0002);
    @(negedge clk);
    chk(irq == 1'b1, "R8", "irq two cycles after zero start", irq, 1);
    chk(saw_req == 0, "R8", "no bus request on zero count", saw_req, 0);
    chk(mem_cycles == 0 && per_given == 0, "R8", "no cycles on zero count",
        mem_cycles + per_given, 0);
    clear_irq();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    reset_env(0, 0, 0);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_only();
    t_inbound();
    t_outbound();
    t_busy_ignore();
    t_zero();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule